// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a build-time number of interrupt inputs into per-input status latches and drives one request line towards a processor. At build time each input is set as edge-triggered or level-triggered. A processor reaches eight 32-bit word registers through a simple single-cycle register port. A direct enable register masks the latches, and two alias registers set or clear enable bits without a read-modify-write. The processor acknowledges a latch by writing a one to its bit. A vector register names the input to service next.

A small state machine holds the global control. It has four named states. `MS_OFF`: nothing is enabled. `MS_TEST`: the global enable is on and the hardware mode is off, so software can inject test interrupts. `MS_HW_HELD`: the hardware mode is on and the global enable is off. `MS_HW_RUN`: both are on. A write to the master register is the only event that moves the machine. From `MS_OFF` or `MS_TEST`, the written bits {hw, en} select the next state: 00 gives `MS_OFF`, 01 gives `MS_TEST`, 10 gives `MS_HW_HELD` and 11 gives `MS_HW_RUN`. From `MS_HW_HELD` or `MS_HW_RUN`, only bit 0 counts: 1 gives `MS_HW_RUN` and 0 gives `MS_HW_HELD`. The hardware mode is therefore left only through reset.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, status, enable and master read zero, the vector reads 0xFFFFFFFF and `irq_req` is low.
- R2: Word 2 (enable) loads the written bits. A write to word 4 (set alias) sets each enable bit whose data bit is 1 and leaves the others unchanged.
- R3: A write to word 5 (clear alias) clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R4: A write to word 3 (acknowledge) clears each status bit whose data bit is 1. Writing all ones clears every latch whose input is not setting it.
- R5: An edge input (EDGE_MASK bit 1; inputs 0 to 3 by default) sets its status bit on the clock after a rising edge. The bit stays set after the input falls. Holding the input high does not set the bit again after an acknowledge.
- R6: A level input (EDGE_MASK bit 0; inputs 4 to 7 by default) sets its status bit on every clock on which it is high, so an acknowledge has no lasting effect while the input stays high. Once the input is low, an acknowledge clears the bit.
- R7: Word 1 (pending) reads status AND enable.
- R8: Word 6 (vector) reads the lowest-numbered pending index, or 0xFFFFFFFF when nothing is pending.
- R9: `irq_req` is high exactly when master bit 0 (global enable) and master bit 1 (hardware mode) are both set and at least one bit is pending. Word 7 reads {hw, en} in bits 1:0.
- R10: While the hardware mode is off, a write to word 0 (status) sets each status bit whose data bit is 1. Once the hardware mode is on, such writes have no effect.
- R11: Writing 0 to master bit 1 does not clear the hardware mode. Master bit 0 can still be turned on and off.
- R12: Register bits at and above NUM_IRQ read zero, and writing to them has no effect. Words 3, 4 and 5 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Interrupt inputs, bit i is input i |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_sel | input | 3 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_sel`, combinational |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that `irq_in` and the register port change only between clock edges and are steady at each rising edge. The edge-capture properties also assume that an input's previous value is the one sampled at the prior edge. The bench drives every input on the falling edge and samples read data just after it, so each stimulus is settled a half period before the edge that captures it. Test interrupts are injected only before the hardware mode is turned on. The master tests run after a fresh reset wherever a check needs the hardware mode off again.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        W_STATUS  = 3'd0,
        W_PENDING = 3'd1,
        W_ENABLE  = 3'd2,
        W_ACK     = 3'd3,
        W_SET_EN  = 3'd4,
        W_CLR_EN  = 3'd5,
        W_VECTOR  = 3'd6,
        W_MASTER  = 3'd7
    } reg_word_e;

    typedef enum logic [1:0] {
        MS_OFF     = 2'd0,
        MS_TEST    = 2'd1,
        MS_HW_HELD = 2'd2,
        MS_HW_RUN  = 2'd3
    } master_state_e;

endpackage

// File: rtl/irq_ctrl_master.sv
module irq_ctrl_master
    import irq_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_master,
    input  logic [1:0] wr_bits,
    output logic       glob_en,
    output logic       hw_mode
);

    master_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_master) begin
            unique case (state_q)
                MS_OFF, MS_TEST: begin
                    unique case (wr_bits)
                        2'b00: state_d = MS_OFF;
                        2'b01: state_d = MS_TEST;
                        2'b10: state_d = MS_HW_HELD;
                        2'b11: state_d = MS_HW_RUN;
                        default: state_d = MS_OFF;
                    endcase
                end
                MS_HW_HELD, MS_HW_RUN: begin
                    state_d = wr_bits[0] ? MS_HW_RUN : MS_HW_HELD;
                end
                default: state_d = MS_OFF;
            endcase
        end
    end

    always_comb begin
        glob_en = 1'b0;
        hw_mode = 1'b0;
        unique case (state_q)
            MS_OFF:     begin glob_en = 1'b0; hw_mode = 1'b0; end
            MS_TEST:    begin glob_en = 1'b1; hw_mode = 1'b0; end
            MS_HW_HELD: begin glob_en = 1'b0; hw_mode = 1'b1; end
            MS_HW_RUN:  begin glob_en = 1'b1; hw_mode = 1'b1; end
            default:    begin glob_en = 1'b0; hw_mode = 1'b0; end
        endcase
    end

    // R11
    hw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode |=> hw_mode);

    // R11
    en_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_master |=> (glob_en == $past(wr_bits[0])));

endmodule

// File: rtl/irq_ctrl_capture.sv
module irq_ctrl_capture #(
    parameter int          NUM_IRQ   = 8,
    parameter logic [31:0] EDGE_MASK = 32'h0000_000F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] ack_clr,
    input  logic [NUM_IRQ-1:0] sw_set,
    output logic [NUM_IRQ-1:0] status_q
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;
            logic rise;
            assign rise = irq_in[i] & ~prev_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q      <= 1'b0;
                    status_q[i] <= 1'b0;
                end else begin
                    prev_q      <= irq_in[i];
                    status_q[i] <= (status_q[i] & ~ack_clr[i]) | rise | sw_set[i];
                end
            end

            // R5
            edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_in[i]) |=> status_q[i]);
        end else begin : g_level
            always_ff @(posedge clk) begin
                if (!rst_n) status_q[i] <= 1'b0;
                else        status_q[i] <= (status_q[i] & ~ack_clr[i]) | irq_in[i] | sw_set[i];
            end

            // R6
            level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_in[i] |=> status_q[i]);
        end

        // R4
        ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_clr[i] && !irq_in[i] && !sw_set[i] && !$rose(irq_in[i])) |=> !status_q[i]);
    end

endmodule

// File: rtl/irq_ctrl_prio.sv
module irq_ctrl_prio #(
    parameter int NUM_IRQ = 8,
    localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pending,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (pending[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R8
    vec_points_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> pending[idx]);

    // R8
    vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((pending & ((NUM_IRQ'(1) << idx) - NUM_IRQ'(1))) == '0));

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int          NUM_IRQ   = 8,
    parameter logic [31:0] EDGE_MASK = 32'h0000_000F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               bus_we,
    input  logic [2:0]         bus_sel,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_req
);

    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    reg_word_e          word;
    logic [NUM_IRQ-1:0] wmask;
    logic [NUM_IRQ-1:0] enable_q;
    logic [NUM_IRQ-1:0] status;
    logic [NUM_IRQ-1:0] pending;
    logic [NUM_IRQ-1:0] ack_clr;
    logic [NUM_IRQ-1:0] sw_set;
    logic               glob_en;
    logic               hw_mode;
    logic               vec_hit;
    logic [IDX_W-1:0]   vec_idx;

    assign word  = reg_word_e'(bus_sel);
    assign wmask = bus_wdata[NUM_IRQ-1:0];

    assign ack_clr = (bus_we && word == W_ACK) ? wmask : '0;
    assign sw_set  = (bus_we && word == W_STATUS && !hw_mode) ? wmask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (bus_we) begin
            unique case (word)
                W_ENABLE: enable_q <= wmask;
                W_SET_EN: enable_q <= enable_q | wmask;
                W_CLR_EN: enable_q <= enable_q & ~wmask;
                default:  enable_q <= enable_q;
            endcase
        end
    end

    irq_ctrl_master u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_master (bus_we && word == W_MASTER),
        .wr_bits   (bus_wdata[1:0]),
        .glob_en   (glob_en),
        .hw_mode   (hw_mode)
    );

    irq_ctrl_capture #(
        .NUM_IRQ   (NUM_IRQ),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .ack_clr  (ack_clr),
        .sw_set   (sw_set),
        .status_q (status)
    );

    assign pending = status & enable_q;

    irq_ctrl_prio #(
        .NUM_IRQ (NUM_IRQ)
    ) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .hit     (vec_hit),
        .idx     (vec_idx)
    );

    assign irq_req = glob_en & hw_mode & vec_hit;

    always_comb begin
        bus_rdata = '0;
        unique case (word)
            W_STATUS:  bus_rdata[NUM_IRQ-1:0] = status;
            W_PENDING: bus_rdata[NUM_IRQ-1:0] = pending;
            W_ENABLE:  bus_rdata[NUM_IRQ-1:0] = enable_q;
            W_VECTOR:  bus_rdata = vec_hit ? 32'(vec_idx) : '1;
            W_MASTER:  bus_rdata[1:0] = {hw_mode, glob_en};
            default:   bus_rdata = '0;
        endcase
    end

    // R2
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && word == W_SET_EN) |=>
            ((enable_q & $past(wmask)) == $past(wmask)) &&
            ((enable_q & ~$past(wmask)) == ($past(enable_q) & ~$past(wmask))));

    // R3
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && word == W_CLR_EN) |=>
            ((enable_q & $past(wmask)) == '0) &&
            ((enable_q & ~$past(wmask)) == ($past(enable_q) & ~$past(wmask))));

    // R9
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (glob_en && hw_mode && (pending != '0)));

    // R10
    sw_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mode |-> (sw_set == '0));

endmodule

// File: tb/irq_ctrl_top_tb_top.sv
module irq_ctrl_top_tb_top;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_sel = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl_top #(.NUM_IRQ(N), .EDGE_MASK(32'h0000_000F)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] data);
        @(negedge clk);
        bus_sel = sel;
        #1 data = bus_rdata;
    endtask

    task automatic set_in(input int idx, input logic v);
        @(negedge clk);
        irq_in[idx] = v;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_in = '0; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(3'd0, v); check("R1 status", v, 32'h0);
        rd(3'd2, v); check("R1 enable", v, 32'h0);
        rd(3'd7, v); check("R1 master", v, 32'h0);
        rd(3'd6, v); check("R1 vector", v, 32'hFFFF_FFFF);
        check("R1 irq_req", {31'b0, irq_req}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(3'd2, 32'h0000_0011);
        rd(3'd2, v); check("R2 direct enable", v, 32'h11);
        wr(3'd4, 32'h0000_0006);
        rd(3'd2, v); check("R2 set alias", v, 32'h17);
        wr(3'd5, 32'h0000_0012);
        rd(3'd2, v); check("R3 clear alias", v, 32'h05);
        rd(3'd4, v); check("R12 set alias reads zero", v, 32'h0);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        set_in(0, 1'b1);
        rd(3'd0, v); check("R5 edge latched", v, 32'h01);
        set_in(0, 1'b0);
        rd(3'd0, v); check("R5 edge held after fall", v, 32'h01);
        set_in(1, 1'b1);
        wr(3'd3, 32'h0000_0001);
        rd(3'd0, v); check("R4 ack clears only bit 0", v, 32'h02);
        rd(3'd3, v); check("R12 ack reads zero", v, 32'h0);
        wr(3'd3, 32'h0000_0002);
        repeat (3) @(negedge clk);
        rd(3'd0, v); check("R5 steady high no retrigger", v, 32'h0);
        set_in(1, 1'b0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        set_in(4, 1'b1);
        rd(3'd0, v); check("R6 level latched", v, 32'h10);
        wr(3'd3, 32'h0000_0010);
        rd(3'd0, v); check("R6 ack while high", v, 32'h10);
        set_in(4, 1'b0);
        rd(3'd0, v); check("R6 held after drop", v, 32'h10);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R4 ack all ones", v, 32'h0);
    endtask

    task automatic t_pending_vector();
        logic [31:0] v;
        wr(3'd0, 32'h0000_00A4);
        rd(3'd0, v); check("R10 test set", v, 32'hA4);
        wr(3'd2, 32'h0000_00A0);
        rd(3'd1, v); check("R7 pending", v, 32'hA0);
        rd(3'd6, v); check("R8 vector lowest", v, 32'd5);
        wr(3'd2, 32'h0);
        rd(3'd6, v); check("R8 vector none", v, 32'hFFFF_FFFF);
        wr(3'd2, 32'h0000_00FF);
        rd(3'd1, v); check("R7 pending all", v, 32'hA4);
        rd(3'd6, v); check("R8 vector bit2", v, 32'd2);
    endtask

    task automatic t_master();
        logic [31:0] v;
        wr(3'd7, 32'h1);
        #1 check("R9 en only no req", {31'b0, irq_req}, 32'h0);
        wr(3'd7, 32'h3);
        #1 check("R9 req raised", {31'b0, irq_req}, 32'h1);
        rd(3'd7, v); check("R9 master readback", v, 32'h3);
        wr(3'd7, 32'h0);
        rd(3'd7, v); check("R11 hw mode sticky", v, 32'h2);
        check("R9 req off with en clear", {31'b0, irq_req}, 32'h0);
        wr(3'd7, 32'h1);
        #1 check("R11 en toggles back", {31'b0, irq_req}, 32'h1);
        wr(3'd0, 32'h0000_0008);
        rd(3'd0, v); check("R10 test write ignored", v, 32'hA4);
        wr(3'd3, 32'hFFFF_FFFF);
        #1 check("R9 req drops after ack", {31'b0, irq_req}, 32'h0);
    endtask

    task automatic t_high_bits();
        logic [31:0] v;
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R12 enable upper bits", v, 32'hFF);
        wr(3'd5, 32'hFFFF_FF00);
        rd(3'd2, v); check("R12 clear upper no effect", v, 32'hFF);
        rd(3'd5, v); check("R12 clear alias reads zero", v, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_enable();
        t_edge();
        t_level();
        t_pending_vector();
        t_master();
        t_high_bits();
        finish_run();
    end

    initial begin
        #200000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule